// File: doc/BRIEF.md
# Host I/O Window Decoder

This block decides whether a host I/O access belongs on the LPC side of the chip. It holds four programmable windows. Each window is one 32-bit register that carries an enable bit, a base address and a mask. A valid 16-bit I/O address is compared against every enabled window. The block raises a hit flag and reports which window claimed the address.

Matching is done on whole dwords. The two low address bits are always treated as "don't care", so the smallest window covers four consecutive ports. Setting more mask bits widens a window to any aligned power-of-two block of at least four ports. Configuration software reaches the four window registers through a simple 32-bit register port with a byte offset.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, all four window registers read back as 0, and no address produces a hit.
- R2: Window k (k = 0..3) sits at configuration offset 0x84 + 4*k. A write with `cfg_wr` high takes effect at the next rising clock edge. `cfg_rdata` shows the addressed register combinationally and returns the full 32-bit value written.
- R3: A write to any other offset changes no window register, including the offsets 0x80 and 0x94 and a misaligned offset such as 0x85. A read of such an offset returns 0.
- R4: A window whose register bit 0 is 0 never matches, whatever its base and mask fields hold.
- R5: For a window register r, the base is {r[15:2], 2'b00} and the mask is {r[31:18], 2'b11}. An address a matches when (a & ~mask) == base. This means a base bit that lies under a set mask bit makes the window unmatchable.
- R6: A window written with 0x00000911 matches exactly the ports 0x910, 0x911, 0x912 and 0x913. It does not match 0x90F or 0x914.
- R7: When several enabled windows match, `io_win_idx` reports the lowest-numbered one.
- R8: `io_hit` and `io_win_idx` are combinational from `io_addr` and `io_valid`. While `io_valid` is 0, or when no window matches, `io_hit` is 0 and `io_win_idx` is 0.
- R9: Mask field bits widen a window. With a base of 0x400 and a mask of 0x00FF, every port from 0x400 to 0x4FF matches and 0x3FF and 0x500 do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Byte offset of the configuration access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed register, 0 if unmapped |
| io_valid | input | 1 | Qualifies `io_addr` as a live I/O cycle |
| io_addr | input | 16 | Host I/O address to decode |
| io_hit | output | 1 | Address falls inside an enabled window |
| io_win_idx | output | 2 | Index of the lowest matching window |

## Verification
The assertions assume that `rst_n` is applied before any configuration write. They also assume that `cfg_wr`, `cfg_addr` and `cfg_wdata` are stable around the rising edge, and that `io_valid` is never X.

The bench drives every input at the falling edge and holds it across the rising edge. It asserts reset from time zero. It changes the I/O address only while the configuration port is idle, so each decode result depends on settled register contents.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int unsigned WIN_REG_W = 32;
  localparam int unsigned IO_ADDR_W = 16;

  typedef logic [WIN_REG_W-1:0] win_reg_t;
  typedef logic [IO_ADDR_W-1:0] io_addr_t;

  // base address: register bits 15:2, low two bits zero
  function automatic io_addr_t win_base(input win_reg_t r);
    return {r[15:2], 2'b00};
  endfunction

  // don't-care mask: register bits 31:18 moved down, low two bits forced set
  function automatic io_addr_t win_mask(input win_reg_t r);
    return {r[31:18], 2'b11};
  endfunction

  function automatic logic win_enabled(input win_reg_t r);
    return r[0];
  endfunction

  function automatic logic win_covers(input io_addr_t a, input win_reg_t r);
    return win_enabled(r) && ((a & ~win_mask(r)) == win_base(r));
  endfunction

endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] BASE_OFS = 8'h84
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  win_reg_t                    cfg_wdata,
  output win_reg_t                    cfg_rdata,
  output logic [NUM_WIN-1:0][WIN_REG_W-1:0] win_regs
);

  localparam int unsigned STRIDE = WIN_REG_W / 8;

  logic [NUM_WIN-1:0] slot_sel;
  logic [NUM_WIN-1:0] slot_wr;
  logic               any_slot_wr;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_slot
    localparam logic [CFG_AW-1:0] SLOT_OFS = BASE_OFS + CFG_AW'(STRIDE * gi);

    assign slot_sel[gi] = (cfg_addr == SLOT_OFS);
    assign slot_wr[gi]  = cfg_wr && slot_sel[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_regs[gi] <= '0;
      end else if (slot_wr[gi]) begin
        win_regs[gi] <= cfg_wdata;
      end
    end

    // write to a mapped slot lands on the next edge
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr[gi] |=> (win_regs[gi] == $past(cfg_wdata)));
  end

  assign any_slot_wr = |slot_wr;

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (slot_sel[i]) cfg_rdata = cfg_rdata | win_regs[i];
    end
  end

  // writes outside the window slots leave every register untouched
  assert_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !any_slot_wr) |=> $stable(win_regs));

  // address decode selects at most one slot
  assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));

endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  io_addr_t                          io_addr,
  input  logic [NUM_WIN-1:0][WIN_REG_W-1:0] win_regs,
  output logic [NUM_WIN-1:0]                match_vec
);

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
    io_addr_t base_w;
    io_addr_t mask_w;
    logic     en_w;

    assign base_w = win_base(win_regs[gi]);
    assign mask_w = win_mask(win_regs[gi]);
    assign en_w   = win_enabled(win_regs[gi]);

    assign match_vec[gi] = en_w && ((io_addr & ~mask_w) == base_w);

    // a disabled window stays silent
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !win_regs[gi][0] |-> !match_vec[gi]);

    // a claimed address agrees with the unmasked register bits
    assert_low_bits_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[gi] |-> (io_addr[15:2] & ~win_regs[gi][31:18]) == win_regs[gi][15:2]);
  end

endmodule

// File: rtl/iowin_prio.sv
module iowin_prio #(
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_WIN-1:0] match_vec,
  output logic               any_match,
  output logic [IDX_W-1:0]   first_idx
);

  always_comb begin
    first_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_vec[i]) first_idx = IDX_W'(i);
    end
  end

  assign any_match = |match_vec;

  // chosen window really matches and nothing below it does
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> (match_vec[first_idx] &&
                   ((match_vec & ((NUM_WIN)'(1) << first_idx) - (NUM_WIN)'(1)) == '0)));

  assert_idle_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_match |-> (first_idx == '0));

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] BASE_OFS = 8'h84,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [WIN_REG_W-1:0] cfg_wdata,
  output logic [WIN_REG_W-1:0] cfg_rdata,
  input  logic                 io_valid,
  input  logic [IO_ADDR_W-1:0] io_addr,
  output logic                 io_hit,
  output logic [IDX_W-1:0]     io_win_idx
);

  logic [NUM_WIN-1:0][WIN_REG_W-1:0] win_regs;
  logic [NUM_WIN-1:0]                match_vec;
  logic                              any_match;
  logic [IDX_W-1:0]                  first_idx;

  iowin_regfile #(
    .NUM_WIN (NUM_WIN),
    .CFG_AW  (CFG_AW),
    .BASE_OFS(BASE_OFS)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .win_regs (win_regs)
  );

  iowin_match #(
    .NUM_WIN(NUM_WIN)
  ) match_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .win_regs (win_regs),
    .match_vec(match_vec)
  );

  iowin_prio #(
    .NUM_WIN(NUM_WIN)
  ) prio_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_vec(match_vec),
    .any_match(any_match),
    .first_idx(first_idx)
  );

  assign io_hit     = io_valid && any_match;
  assign io_win_idx = io_hit ? first_idx : '0;

  // no claim outside a live I/O cycle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> (!io_hit && io_win_idx == '0));

  // a hit always traces back to some matching window
  assert_hit_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (match_vec != '0));

endmodule

// File: tb/io_window_decoder_tb.sv
`timescale 1ns/1ps
module io_window_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        io_valid;
  logic [15:0] io_addr;
  logic        io_hit;
  logic [1:0]  io_win_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  logic [31:0] shadow [4];

  io_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
    .io_addr(io_addr), .io_hit(io_hit), .io_win_idx(io_win_idx)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // slot index for a byte offset, -1 when not a window slot
  function automatic int slot_of(input logic [7:0] ofs);
    case (ofs)
      8'h84: return 0;
      8'h88: return 1;
      8'h8C: return 2;
      8'h90: return 3;
      default: return -1;
    endcase
  endfunction

  // bitwise restatement of the window rule
  function automatic bit ref_one(input logic [15:0] a, input logic [31:0] r);
    if (!r[0]) return 0;
    for (int j = 2; j < 16; j++) begin
      if (r[16+j]) begin
        if (r[j]) return 0;
      end else if (a[j] != r[j]) return 0;
    end
    return 1;
  endfunction

  task automatic wr(input logic [7:0] ofs, input logic [31:0] val);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = ofs; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 0;
    if (slot_of(ofs) >= 0) shadow[slot_of(ofs)] = val;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] ofs, input logic [31:0] exp);
    cfg_addr = ofs; #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic probe(input string req, input logic v, input logic [15:0] a,
                       input logic exp_hit, input logic [1:0] exp_idx);
    io_valid = v; io_addr = a; #1;
    chk(req, {31'd0, io_hit}, {31'd0, exp_hit});
    chk(req, {30'd0, io_win_idx}, {30'd0, exp_idx});
  endtask

  task automatic probe_ref(input string req, input logic [15:0] a);
    bit h = 0; logic [1:0] ix = 0;
    for (int w = 3; w >= 0; w--) if (ref_one(a, shadow[w])) begin h = 1; ix = 2'(w); end
    probe(req, 1'b1, a, h, ix);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(8'h84 + 8'(4*k), 32'h0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) rd_chk("R1 reset value", 8'h84 + 8'(4*k), 32'h0);
    probe("R1 no hit after reset", 1'b1, 16'h0000, 1'b0, 2'd0);
    probe("R1 no hit after reset", 1'b1, 16'h0910, 1'b0, 2'd0);
  endtask

  task automatic t_readback();
    wr(8'h84, 32'hDEAD_BEE0);
    wr(8'h88, 32'h1234_5679);
    wr(8'h8C, 32'hFFFF_FFFE);
    wr(8'h90, 32'h0000_0911);
    rd_chk("R2 readback w0", 8'h84, 32'hDEAD_BEE0);
    rd_chk("R2 readback w1", 8'h88, 32'h1234_5679);
    rd_chk("R2 readback w2", 8'h8C, 32'hFFFF_FFFE);
    rd_chk("R2 readback w3", 8'h90, 32'h0000_0911);
  endtask

  task automatic t_stray();
    wr(8'h80, 32'hAAAA_AAAB);
    wr(8'h94, 32'h5555_5555);
    wr(8'h85, 32'h0000_0911);
    rd_chk("R3 unmapped read 0x80", 8'h80, 32'h0);
    rd_chk("R3 unmapped read 0x94", 8'h94, 32'h0);
    rd_chk("R3 unmapped read 0x85", 8'h85, 32'h0);
    for (int k = 0; k < 4; k++)
      rd_chk("R3 slot unchanged", 8'h84 + 8'(4*k), shadow[k]);
  endtask

  task automatic t_single();
    clear_all();
    wr(8'h8C, 32'h0000_0911);
    probe("R6 below window", 1'b1, 16'h090F, 1'b0, 2'd0);
    for (int p = 16'h0910; p <= 16'h0913; p++)
      probe("R6 inside window", 1'b1, 16'(p), 1'b1, 2'd2);
    probe("R6 above window", 1'b1, 16'h0914, 1'b0, 2'd0);
  endtask

  task automatic t_disabled();
    clear_all();
    wr(8'h84, 32'h0000_0910);
    probe("R4 disabled window", 1'b1, 16'h0910, 1'b0, 2'd0);
    wr(8'h84, 32'hFFFC_0000);
    probe("R4 disabled wide mask", 1'b1, 16'h1234, 1'b0, 2'd0);
  endtask

  task automatic t_mask();
    clear_all();
    wr(8'h88, 32'h00FC_0401);
    probe("R9 wide low edge", 1'b1, 16'h0400, 1'b1, 2'd1);
    probe("R9 wide middle", 1'b1, 16'h0477, 1'b1, 2'd1);
    probe("R9 wide top edge", 1'b1, 16'h04FF, 1'b1, 2'd1);
    probe("R9 wide below", 1'b1, 16'h03FF, 1'b0, 2'd0);
    probe("R9 wide above", 1'b1, 16'h0500, 1'b0, 2'd0);
    wr(8'h88, 32'h00FC_0405);
    probe("R5 base bit under mask", 1'b1, 16'h0404, 1'b0, 2'd0);
    probe("R5 base bit under mask", 1'b1, 16'h0400, 1'b0, 2'd0);
  endtask

  task automatic t_priority();
    clear_all();
    wr(8'h90, 32'h00FC_0401);
    wr(8'h84, 32'h0000_0441);
    probe("R7 lowest index wins", 1'b1, 16'h0442, 1'b1, 2'd0);
    probe("R7 only high window", 1'b1, 16'h0450, 1'b1, 2'd3);
    wr(8'h84, 32'h0000_0440);
    probe("R7 after disabling low", 1'b1, 16'h0442, 1'b1, 2'd3);
  endtask

  task automatic t_valid();
    clear_all();
    wr(8'h84, 32'h0000_0911);
    probe("R8 valid low", 1'b0, 16'h0910, 1'b0, 2'd0);
    probe("R8 valid high", 1'b1, 16'h0910, 1'b1, 2'd0);
    probe("R8 valid low again", 1'b0, 16'h0911, 1'b0, 2'd0);
  endtask

  task automatic t_sweep();
    for (int round = 0; round < 6; round++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] rv;
        rv = {10'd0, 4'($urandom), 2'b00, 4'h0, 8'($urandom), 3'($urandom), 1'($urandom)};
        wr(8'h84 + 8'(4*k), rv);
      end
      for (int n = 0; n < 150; n++)
        probe_ref("R5 sweep", {4'h0, 12'($urandom)});
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) shadow[k] = 0;
    rst_n = 0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; io_valid = 0; io_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_stray();
    t_single();
    t_disabled();
    t_mask();
    t_priority();
    t_valid();
    t_sweep();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule